// File: doc/BRIEF.md
# Sliced ALU with Status Register

A 16-bit arithmetic and logic unit built from four chained 4-bit adder slices, together with a 16-bit status register that records the flags of the most recent ALU operation. Operand B passes through an XOR stage controlled by the subtract line. The carry-in is a separate input, so the controller supplies the `+1` of a two's-complement subtract, or a carry arriving from a wider chain.

The result is combinational. Flags are captured into the status register only on cycles where the update strobe is high. The carries that pass between slices are kept as flags of their own. Equality of the operands is reported apart from the zero flag. The negative flag can be switched to the inverted carry for unsigned compares. The top four status bits hold an interrupt-enable bit and a 3-bit pending-interrupt code. These are plain storage that only a software write changes. A software write wins over a flag update in the same cycle.

Status bit map (bit 0 first): Z=0, C=2, QC=3, HC=4, TC=5, EQ=7, N=8, O=9, IE=12, I0..I2=13..15. Bits 1, 6, 10 and 11 are unused.

Top module: `sliced_alu`

## Requirements
- R1: With `logic_op`=00, `result` = (`opnd_a` + (`opnd_b` XOR {16{`sub_en`}}) + `carry_in`) mod 65536. `sub_en` never adds 1 by itself.
- R2: `logic_op`=01 gives A AND B, 10 gives A OR B, 11 gives A XOR B, all on the uninverted B.
- R3: After an arithmetic update, status bit 2 (C) holds the carry out of bit 15. Bits 3, 4 and 5 (QC, HC, TC) hold the carries out of bits 3, 7 and 11.
- R4: After an update, status bit 0 (Z) is 1 exactly when the 16-bit result was zero.
- R5: After an update, status bit 7 (EQ) is 1 exactly when `opnd_a` equalled `opnd_b`, whatever the operation.
- R6: After an update, status bit 8 (N) is result bit 15 when `ucmp_en`=0, and the inverse of the new C when `ucmp_en`=1.
- R7: After an arithmetic update, status bit 9 (O) is 1 exactly when the signed result lies outside -32768..+32767 (e.g. 32668+400).
- R8: After a logic-operation update, C, QC, HC, TC and O are 0.
- R9: Flag bits change only on a clock edge where `flag_upd` is 1. The new value is visible after that edge. Without `flag_upd` or `stat_we`, the whole status word holds.
- R10: On an edge with `stat_we`=1, status takes `stat_wdata` with bits 1, 6, 10 and 11 forced to 0. This write overrides a simultaneous `flag_upd`.
- R11: Bits 1, 6, 10 and 11 always read 0. IE (bit 12) and the interrupt code (bits 13–15) change only through `stat_we`, and survive flag updates.
- R12: While `rst_n` is low, status is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| sub_en | input | 1 | Invert B through XOR |
| carry_in | input | 1 | Carry into bit 0 |
| logic_op | input | 2 | 00 arithmetic, 01 AND, 10 OR, 11 XOR |
| ucmp_en | input | 1 | N follows inverted carry |
| flag_upd | input | 1 | Capture ALU flags this cycle |
| stat_we | input | 1 | Software write of status |
| stat_wdata | input | 16 | Software write data |
| result | output | 16 | Combinational ALU result |
| status | output | 16 | Packed status word |

## Verification
The bench builds the block with its default slice width of 4, which gives four 4-bit slices and a 16-bit datapath. At this size the slice-boundary carries land on the bit positions the status word reserves for them. Because the width is 16, the bench can reach every boundary exhaustively by choice of operands: 0x000F+1 carries out of the first slice only, 0xFFFF+1 carries out of every slice, and 0x7F9C+0x0190 crosses the signed limit. The bench's reference model computes each slice carry as a plain wide sum rather than through a chain.

// File: rtl/sliced_alu.sv
module sliced_alu #(
  parameter int SLICE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [4*SLICE_W-1:0]        opnd_a,
  input  logic [4*SLICE_W-1:0]        opnd_b,
  input  logic                        sub_en,
  input  logic                        carry_in,
  input  logic [1:0]                  logic_op,
  input  logic                        ucmp_en,
  input  logic                        flag_upd,
  input  logic                        stat_we,
  input  logic [15:0]                 stat_wdata,
  output logic [4*SLICE_W-1:0]        result,
  output logic [15:0]                 status
);
  localparam int SLICES = 4;
  localparam int W = SLICE_W * SLICES;
  localparam logic [15:0] USED_MASK = 16'hF3BD;
  localparam logic [15:0] IRQ_MASK  = 16'hF000;

  logic [W-1:0] b_x, sum;
  logic [SLICES:0] cy;
  logic arith, c_msb_in;
  logic f_c, f_o, f_z, f_eq, f_n;
  logic [15:0] alu_bits;

  assign b_x   = opnd_b ^ {W{sub_en}};
  assign cy[0] = carry_in;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [SLICE_W:0] part;
    assign part = {1'b0, opnd_a[s*SLICE_W +: SLICE_W]} + {1'b0, b_x[s*SLICE_W +: SLICE_W]}
                + {{SLICE_W{1'b0}}, cy[s]};
    assign sum[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
    assign cy[s+1] = part[SLICE_W];
  end

  always_comb begin
    case (logic_op)
      2'b01:   result = opnd_a & opnd_b;
      2'b10:   result = opnd_a | opnd_b;
      2'b11:   result = opnd_a ^ opnd_b;
      default: result = sum;
    endcase
  end

  assign arith    = (logic_op == 2'b00);
  assign c_msb_in = opnd_a[W-1] ^ b_x[W-1] ^ sum[W-1];
  assign f_c      = arith & cy[SLICES];
  assign f_o      = arith & (c_msb_in ^ cy[SLICES]);
  assign f_z      = (result == '0);
  assign f_eq     = (opnd_a == opnd_b);
  assign f_n      = ucmp_en ? ~f_c : result[W-1];

  always_comb begin
    alu_bits    = '0;
    alu_bits[0] = f_z;
    alu_bits[2] = f_c;
    alu_bits[3] = arith & cy[1];
    alu_bits[4] = arith & cy[2];
    alu_bits[5] = arith & cy[3];
    alu_bits[7] = f_eq;
    alu_bits[8] = f_n;
    alu_bits[9] = f_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        status <= '0;
    else if (stat_we)  status <= stat_wdata & USED_MASK;
    else if (flag_upd) status <= (status & IRQ_MASK) | alu_bits;
  end
endmodule

module sliced_alu_chk #(
  parameter int SLICE_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [4*SLICE_W-1:0] opnd_a,
  input logic [4*SLICE_W-1:0] opnd_b,
  input logic                 sub_en,
  input logic                 carry_in,
  input logic [1:0]           logic_op,
  input logic                 ucmp_en,
  input logic                 flag_upd,
  input logic                 stat_we,
  input logic [15:0]          stat_wdata,
  input logic [4*SLICE_W-1:0] result,
  input logic [15:0]          status
);
  p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 16'h0C42) == 16'h0);

  p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> status == ($past(stat_wdata) & 16'hF3BD));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we && !flag_upd) |=> $stable(status));

  p_irq_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !stat_we) |=> status[15:12] == $past(status[15:12]));

  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !stat_we) |=> status[0] == ($past(result) == '0));

  p_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !stat_we) |=> status[7] == ($past(opnd_a) == $past(opnd_b)));

  p_logic_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !stat_we && logic_op != 2'b00) |=> (status[5:2] == 4'h0 && !status[9]));

  p_ucmp_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !stat_we && ucmp_en) |=> status[8] == !status[2]);

  p_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_op == 2'b01) |-> result == (opnd_a & opnd_b));
endmodule

bind sliced_alu sliced_alu_chk #(.SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/sliced_alu_test.sv
module sliced_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a = '0, b = '0, wdata = '0;
  logic sub = 0, cin = 0, ucmp = 0, upd = 0, we = 0;
  logic [1:0] op = 2'b00;
  logic [15:0] result, status;
  logic [15:0] exp_stat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sliced_alu uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .sub_en(sub), .carry_in(cin),
    .logic_op(op), .ucmp_en(ucmp), .flag_upd(upd), .stat_we(we), .stat_wdata(wdata),
    .result(result), .status(status)
  );

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_res(input logic [15:0] x, input logic [15:0] y,
                                            input logic s, input logic c, input logic [1:0] o);
    logic [16:0] full;
    full = {1'b0, x} + {1'b0, y ^ {16{s}}} + {16'h0, c};
    case (o)
      2'b01:   return x & y;
      2'b10:   return x | y;
      2'b11:   return x ^ y;
      default: return full[15:0];
    endcase
  endfunction

  function automatic logic [15:0] model_flags(input logic [15:0] x, input logic [15:0] y,
      input logic s, input logic c, input logic [1:0] o, input logic u);
    logic [15:0] yx, r, f;
    logic [16:0] full;
    logic [4:0] q;
    logic [8:0] h;
    logic [12:0] t;
    logic ar;
    yx = y ^ {16{s}};
    full = {1'b0, x} + {1'b0, yx} + {16'h0, c};
    q = {1'b0, x[3:0]} + {1'b0, yx[3:0]} + {4'h0, c};
    h = {1'b0, x[7:0]} + {1'b0, yx[7:0]} + {8'h0, c};
    t = {1'b0, x[11:0]} + {1'b0, yx[11:0]} + {12'h0, c};
    ar = (o == 2'b00);
    r = model_res(x, y, s, c, o);
    f = '0;
    f[0] = (r == 16'h0);
    f[2] = ar & full[16];
    f[3] = ar & q[4];
    f[4] = ar & h[8];
    f[5] = ar & t[12];
    f[7] = (x == y);
    f[8] = u ? ~f[2] : r[15];
    f[9] = ar & (x[15] == yx[15]) & (r[15] != x[15]);
    return f;
  endfunction

  task automatic run_op(input string tag, input logic [15:0] x, input logic [15:0] y,
                        input logic s, input logic c, input logic [1:0] o, input logic u);
    @(negedge clk);
    a = x; b = y; sub = s; cin = c; op = o; ucmp = u; upd = 1; we = 0;
    #1 check16({tag, " result R1/R2"}, result, model_res(x, y, s, c, o));
    exp_stat = (exp_stat & 16'hF000) | model_flags(x, y, s, c, o, u);
    @(negedge clk);
    upd = 0;
    check16({tag, " status R3-flags"}, status, exp_stat);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check16("R12 reset", status, 16'h0);
    rst_n = 1;
    exp_stat = 16'h0;
  endtask

  task automatic t_arith;
    run_op("R1 add", 16'h1234, 16'h0101, 0, 0, 2'b00, 0);
    run_op("R7 overflow", 16'h7F9C, 16'h0190, 0, 0, 2'b00, 0);
    check16("R7 O bit", {15'h0, status[9]}, 16'h1);
    run_op("R3 qc only", 16'h000F, 16'h0001, 0, 0, 2'b00, 0);
    check16("R3 QC set", status & 16'h003C, 16'h0008);
    run_op("R3 all carries", 16'hFFFF, 16'h0001, 0, 0, 2'b00, 0);
    check16("R3 C/QC/HC/TC", status & 16'h003D, 16'h003D);
    run_op("R1 sub equal R4 R5", 16'h0005, 16'h0005, 1, 1, 2'b00, 0);
    check16("R4 Z and R5 EQ", status & 16'h0081, 16'h0081);
    run_op("R1 sub no cin", 16'h0005, 16'h0005, 1, 0, 2'b00, 0);
    run_op("R7 neg overflow", 16'h8000, 16'h0001, 1, 1, 2'b00, 0);
  endtask

  task automatic t_logic;
    run_op("R2 and", 16'hF0F0, 16'hFF00, 0, 1, 2'b01, 0);
    run_op("R2 or", 16'h00F0, 16'h0F00, 1, 0, 2'b10, 0);
    run_op("R8 xor equal", 16'hA5A5, 16'hA5A5, 0, 1, 2'b11, 0);
    check16("R8 cleared carries", status & 16'h023C, 16'h0);
  endtask

  task automatic t_unsigned;
    run_op("R6 ucmp borrow", 16'h0003, 16'h0005, 1, 1, 2'b00, 1);
    check16("R6 N=~C borrow", status & 16'h0104, 16'h0100);
    run_op("R6 ucmp noborrow", 16'h8005, 16'h0003, 1, 1, 2'b00, 1);
    check16("R6 N=~C no borrow", status & 16'h0104, 16'h0004);
  endtask

  task automatic t_hold;
    @(negedge clk);
    a = 16'h0000; b = 16'h0000; op = 2'b00; upd = 0; we = 0;
    repeat (2) @(negedge clk);
    check16("R9 hold without strobe", status, exp_stat);
  endtask

  task automatic t_swwrite;
    @(negedge clk);
    we = 1; wdata = 16'hFFFF;
    @(negedge clk);
    we = 0;
    exp_stat = 16'hF3BD;
    check16("R10 masked write", status, exp_stat);
    check16("R11 unused zero", status & 16'h0C42, 16'h0);
    run_op("R11 irq kept", 16'h0001, 16'h0002, 0, 0, 2'b00, 0);
    check16("R11 IE/I bits", status & 16'hF000, 16'hF000);
    @(negedge clk);
    a = 16'h0000; b = 16'h0000; op = 2'b00; upd = 1; we = 1; wdata = 16'h2004;
    @(negedge clk);
    upd = 0; we = 0;
    exp_stat = 16'h2004;
    check16("R10 write beats update", status, exp_stat);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_unsigned();
    t_hold();
    t_swwrite();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule